// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a four-channel, 12-bit converter that samples all of its channels at the same moment. A rising edge on the start input freezes every channel's input word into a hold register in one clock edge. The core then converts each channel picked by the select inputs, one after another in ascending index order. Each conversion takes a fixed, parameterised number of clock cycles. The analog conversion is stood in for by this fixed-latency counter, which copies the frozen stimulus word into a result slot when it expires. A busy flag covers the whole sequence. An active-low end-of-conversion pulse marks each completed channel.

The results fill numbered output slots in conversion order: slot 0 holds the first selected channel. A read pointer picks which slot is presented on the parallel data bus. The pointer always names the newest finished result. It wraps back to slot 0 when the host finishes reading the final result of a sequence. A first-data flag is high whenever the pointer is at slot 0.

The bus is plain control, not a stream. There is no back-pressure: a result that is not read before the next completion is superseded as the pointer target, although it stays in its slot. The pad tri-state buffer sits outside the core and is controlled by the drive-enable output. All inputs are synchronous to `clk`.

Top module: `sampling_seq_core`

## Requirements
- R1: A rising edge of `conv_start`, sampled while `busy` is low and `ch_sel` is non-zero, captures all `NCH` words of `sample_in` in that same edge and raises `busy` in the next cycle; later changes of `sample_in` do not alter the results of that sequence.
- R2: A `conv_start` rising edge seen while `busy` is high, or with `ch_sel` all zero, is ignored: no new sequence starts and no timing or result changes.
- R3: Selected channels convert in ascending channel index. The first completion falls `CONV_CYC` cycles after the start edge, and each further completion falls `CONV_CYC` cycles after the one before.
- R4: At each completion edge `eoc_n` goes low for exactly `EOC_LEN` cycles (1 <= `EOC_LEN` < `CONV_CYC`), giving one pulse per selected channel.
- R5: `busy` stays high from the cycle after the start edge up to, and falls at, the edge of the last completion.
- R6: A result is written into its slot in the same edge that `eoc_n` falls, so a read during the low pulse returns it.
- R7: `db_en` is high exactly when `cs_n` and `rd_n` are both low; `db` is all zeros whenever `db_en` is low.
- R8: At the n-th completion of a sequence the pointer moves to slot n-1, which holds the n-th converted channel; `first_data` is high exactly when the pointer is at slot 0.
- R9: Reads before the next completion that are not of the final result keep returning the same slot.
- R10: A rising edge of `rd_n` with `cs_n` low, taken while the pointer is at the final slot of the latest sequence, returns the pointer to slot 0 and raises `first_data` in the following cycle.
- R11: After reset `busy` is low, `eoc_n` is high, `first_data` is high and `db_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Start strobe, acts on its rising edge |
| ch_sel | input | NCH | Channel select mask, bit i enables channel i |
| sample_in | input | NCH*DW | Stimulus words, channel i at bits [i*DW +: DW] |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| busy | output | 1 | High while a sequence is in progress |
| eoc_n | output | 1 | Active-low end-of-conversion pulse |
| first_data | output | 1 | High while the pointer is at slot 0 |
| db | output | DW | Result at the read pointer, zero when not driven |
| db_en | output | 1 | Drive enable for the external bus buffer |

## Verification
The bench builds the core with `CONV_CYC` = 6 and `EOC_LEN` = 2, keeping four channels of 12 bits. The short conversion lets several dozen full sequences run, each with a random select mask, so every mask width from one to four channels is reached. A sequence can overlap a second start pulse or a change of the stimulus words, and it can see single, repeated or skipped reads. The 6-cycle gap between completions leaves room to read twice inside one interval. It also lets the pointer wrap on the final read and be followed by a stray extra read before the next sequence.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  // Upper bound on channel count handled by the helper functions.
  localparam int MAX_CH = 16;

  // Lowest set index strictly above 'after', or -1 when none remains.
  function automatic int next_set(input logic [MAX_CH-1:0] m, input int after);
    int r;
    r = -1;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (m[i] && (i > after)) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/ssq_ctrl.sv
module ssq_ctrl #(
  parameter int NCH      = 4,
  parameter int CONV_CYC = 206,
  parameter int EOC_LEN  = 13,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_start,
  input  logic [NCH-1:0] ch_sel,
  output logic           go,
  output logic           done,
  output logic [CHW-1:0] cur_ch,
  output logic [CHW-1:0] done_slot,
  output logic [CHW-1:0] last_slot,
  output logic           busy,
  output logic           eoc_n
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int EW = $clog2(EOC_LEN + 1);

  logic                       start_q;
  logic                       busy_r;
  logic [CW-1:0]              cnt;
  logic [NCH-1:0]             mask;
  logic [CHW-1:0]             cur_r;
  logic [CHW-1:0]             slot_r;
  logic [CHW-1:0]             last_r;
  logic [EW-1:0]              eoc_cnt;
  logic                       eoc_r;
  logic [ssq_pkg::MAX_CH-1:0] sel_w;
  logic [ssq_pkg::MAX_CH-1:0] mask_w;
  int                         first_i;
  int                         next_i;

  always_comb begin
    sel_w  = '0;
    mask_w = '0;
    sel_w[NCH-1:0]  = ch_sel;
    mask_w[NCH-1:0] = mask;
    first_i = ssq_pkg::next_set(sel_w, -1);
    next_i  = ssq_pkg::next_set(mask_w, int'(cur_r));
  end

  assign go   = conv_start && !start_q && !busy_r && (|ch_sel);
  assign done = busy_r && (cnt == '0);

  // Sequence state: channel walk and interval counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_r  <= 1'b0;
      cnt     <= '0;
      mask    <= '0;
      cur_r   <= '0;
      slot_r  <= '0;
      last_r  <= '0;
    end else begin
      start_q <= conv_start;
      if (go) begin
        busy_r <= 1'b1;
        mask   <= ch_sel;
        cur_r  <= CHW'(first_i);
        slot_r <= '0;
        last_r <= CHW'($countones(ch_sel) - 1);
        cnt    <= CW'(CONV_CYC - 1);
      end else if (done) begin
        if (next_i >= 0) begin
          cur_r  <= CHW'(next_i);
          slot_r <= slot_r + 1'b1;
          cnt    <= CW'(CONV_CYC - 1);
        end else begin
          busy_r <= 1'b0;
        end
      end else if (busy_r) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // End-of-conversion pulse stretcher.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_r   <= 1'b1;
      eoc_cnt <= '0;
    end else if (done) begin
      eoc_r   <= 1'b0;
      eoc_cnt <= EW'(EOC_LEN - 1);
    end else if (eoc_cnt != '0) begin
      eoc_cnt <= eoc_cnt - 1'b1;
    end else begin
      eoc_r <= 1'b1;
    end
  end

  assign cur_ch    = cur_r;
  assign done_slot = slot_r;
  assign last_slot = last_r;
  assign busy      = busy_r;
  assign eoc_n     = eoc_r;
endmodule

// File: rtl/ssq_bank.sv
module ssq_bank #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              done,
  input  logic [CHW-1:0]    cur_ch,
  input  logic [CHW-1:0]    done_slot,
  input  logic [NCH*DW-1:0] sample_in,
  input  logic [CHW-1:0]    rd_slot,
  output logic [DW-1:0]     rd_word
);
  logic [DW-1:0] hold [NCH];
  logic [DW-1:0] res  [NCH];
  logic [DW-1:0] conv_word;

  assign conv_word = hold[cur_ch];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // Track/hold: every channel frozen on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hold[g] <= '0;
      else if (go) hold[g] <= sample_in[g*DW +: DW];
    end

    // Output slot g, filled by the g-th completion of a sequence.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             res[g] <= '0;
      else if (done && (done_slot == CHW'(g))) res[g] <= conv_word;
    end
  end

  assign rd_word = res[rd_slot];
endmodule

// File: rtl/ssq_rdport.sv
module ssq_rdport #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           done,
  input  logic [CHW-1:0] done_slot,
  input  logic [CHW-1:0] last_slot,
  input  logic [DW-1:0]  rd_word,
  output logic [CHW-1:0] ptr,
  output logic           first_data,
  output logic [DW-1:0]  db,
  output logic           db_en
);
  logic           rd_q;
  logic           rd_rise;
  logic [CHW-1:0] ptr_r;

  assign rd_rise = rd_n && !rd_q && !cs_n;

  // A completion outranks a wrap in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b1;
      ptr_r <= '0;
    end else begin
      rd_q <= rd_n;
      if (done)                                ptr_r <= done_slot;
      else if (rd_rise && (ptr_r == last_slot)) ptr_r <= '0;
    end
  end

  assign ptr        = ptr_r;
  assign first_data = (ptr_r == '0);
  assign db_en      = !cs_n && !rd_n;
  assign db         = db_en ? rd_word : '0;
endmodule

// File: rtl/sampling_seq_core.sv
module sampling_seq_core #(
  parameter int NCH      = 4,
  parameter int DW       = 12,
  parameter int CONV_CYC = 206,
  parameter int EOC_LEN  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic [NCH-1:0]    ch_sel,
  input  logic [NCH*DW-1:0] sample_in,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic              busy,
  output logic              eoc_n,
  output logic              first_data,
  output logic [DW-1:0]     db,
  output logic              db_en
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           go;
  logic           done;
  logic [CHW-1:0] cur_ch;
  logic [CHW-1:0] done_slot;
  logic [CHW-1:0] last_slot;
  logic [CHW-1:0] ptr;
  logic [DW-1:0]  rd_word;

  ssq_ctrl #(.NCH(NCH), .CONV_CYC(CONV_CYC), .EOC_LEN(EOC_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ch_sel(ch_sel),
    .go(go), .done(done), .cur_ch(cur_ch), .done_slot(done_slot),
    .last_slot(last_slot), .busy(busy), .eoc_n(eoc_n)
  );

  ssq_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .go(go), .done(done), .cur_ch(cur_ch),
    .done_slot(done_slot), .sample_in(sample_in), .rd_slot(ptr),
    .rd_word(rd_word)
  );

  ssq_rdport #(.NCH(NCH), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .done(done),
    .done_slot(done_slot), .last_slot(last_slot), .rd_word(rd_word),
    .ptr(ptr), .first_data(first_data), .db(db), .db_en(db_en)
  );
endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
  parameter int CONV_CYC = 206,
  parameter int EOC_LEN  = 13
) (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic busy,
  input logic eoc_n,
  input logic first_data,
  input logic cs_n,
  input logic rd_n
);
  logic [31:0] phase;
  logic [31:0] low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (!busy)          phase <= '0;
    else if (phase == 32'(CONV_CYC)) phase <= 32'd1;
    else                     phase <= phase + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_len <= '0;
    else if (!eoc_n) low_len <= low_len + 32'd1;
    else             low_len <= '0;
  end

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(conv_start) && !$past(busy)));

  // R3
  eoc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> (phase == 32'(CONV_CYC)));

  // R4
  eoc_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_len <= 32'(EOC_LEN));

  // R4
  eoc_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_n) |-> (low_len == 32'(EOC_LEN)));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(eoc_n));

  // R10
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(first_data) && eoc_n) |-> ($past(rd_n) && !$past(rd_n, 2) && !$past(cs_n)));
endmodule

bind sampling_seq_core ssq_chk #(.CONV_CYC(CONV_CYC), .EOC_LEN(EOC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .busy(busy),
  .eoc_n(eoc_n), .first_data(first_data), .cs_n(cs_n), .rd_n(rd_n)
);

// File: tb/sim_sampling_seq_core.sv
`timescale 1ns/1ps
module sim_sampling_seq_core;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int C   = 6;
  localparam int L   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              conv_start = 1'b0;
  logic [NCH-1:0]    ch_sel = '0;
  logic [NCH*DW-1:0] sample_in = '0;
  logic              cs_n = 1'b0;
  logic              rd_n = 1'b1;
  logic              busy, eoc_n, first_data, db_en;
  logic [DW-1:0]     db;

  int nchk = 0;
  int nfail = 0;
  int exp_ptr = 0;
  logic [NCH*DW-1:0] frozen;

  always #4 clk = ~clk;

  sampling_seq_core #(.NCH(NCH), .DW(DW), .CONV_CYC(C), .EOC_LEN(L)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ch_sel(ch_sel),
    .sample_in(sample_in), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .eoc_n(eoc_n), .first_data(first_data), .db(db), .db_en(db_en)
  );

  function automatic int nsel(input logic [NCH-1:0] s);
    int n = 0;
    for (int i = 0; i < NCH; i++) if (s[i]) n++;
    return n;
  endfunction

  // Channel index of the k-th selected channel (k from 0), ascending order.
  function automatic int nth_ch(input logic [NCH-1:0] s, input int k);
    int seen = 0;
    int r = 0;
    for (int i = 0; i < NCH; i++) begin
      if (s[i]) begin
        if (seen == k) r = i;
        seen++;
      end
    end
    return r;
  endfunction

  function automatic logic [NCH*DW-1:0] rand_words();
    logic [NCH*DW-1:0] w;
    for (int i = 0; i < NCH; i++) w[i*DW +: DW] = DW'($urandom);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // One sequence; checks every cycle from the start edge (j = 0) onwards.
  task automatic run_seq(input logic [NCH-1:0] s, input bit do_read,
                         input bit dbl, input bit poke);
    int n;
    int k;
    logic [DW-1:0] e;
    n = nsel(s);
    @(negedge clk);
    ch_sel     = s;
    frozen     = rand_words();
    sample_in  = frozen;
    conv_start = 1'b1;
    for (int j = 0; j <= n*C + 5; j++) begin
      @(negedge clk);
      k = j / C;
      if (j >= C && (j % C) == 0 && k <= n) exp_ptr = k - 1;
      if (do_read && j == n*C + 2) exp_ptr = 0;
      // R5 busy window
      chk(busy == (j < n*C), "R5 busy", 32'(busy), 32'(j < n*C));
      // R3 R4 eoc pulse placement and width
      chk(eoc_n == !(k >= 1 && k <= n && (j - k*C) < L), "R4 eoc_n",
          32'(eoc_n), 32'(!(k >= 1 && k <= n && (j - k*C) < L)));
      // R8 R10 first-data flag follows pointer
      chk(first_data == (exp_ptr == 0), "R8 first_data", 32'(first_data),
          32'(exp_ptr == 0));
      if (j == 0) conv_start = 1'b0;
      if (poke && j == 2) begin
        conv_start = 1'b1;
        sample_in  = rand_words();
      end
      if (poke && j == 3) conv_start = 1'b0;
      if (do_read && k >= 1 && k <= n &&
          (j == k*C || (dbl && j == k*C + 3))) begin
        rd_n = 1'b0;
        #1;
        e = frozen[nth_ch(s, exp_ptr)*DW +: DW];
        // R6 R9 R1 result at pointer, frozen at start
        chk(db == e, "R6 db", 32'(db), 32'(e));
        chk(db_en == 1'b1, "R7 db_en", 32'(db_en), 32'd1);
      end
      if (j == k*C + 1 || j == k*C + 4) rd_n = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy", 32'(busy), 32'd0);
    chk(eoc_n == 1'b1, "R11 eoc_n", 32'(eoc_n), 32'd1);
    chk(first_data == 1'b1, "R11 first_data", 32'(first_data), 32'd1);
    chk(db_en == 1'b0, "R11 db_en", 32'(db_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 empty select is ignored
    ch_sel = '0;
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0, "R2 empty select", 32'(busy), 32'd0);
    end

    // R7 read strobe without chip select
    cs_n = 1'b1;
    rd_n = 1'b0;
    #1;
    chk(db_en == 1'b0, "R7 db_en cs high", 32'(db_en), 32'd0);
    chk(db == '0, "R7 db zero", 32'(db), 32'd0);
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;

    // Directed corners: all channels, single channel, skipped reads.
    run_seq(4'b1111, 1'b1, 1'b1, 1'b1);
    run_seq(4'b1000, 1'b1, 1'b0, 1'b0);
    run_seq(4'b0101, 1'b0, 1'b0, 1'b1);
    run_seq(4'b0110, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < 40; i++) begin
      run_seq(NCH'($urandom_range(15, 1)), ($urandom % 4) != 0,
              1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule